// File: doc/BRIEF.md
# Bit-Reversed Vector Address Generator

This block produces the effective addresses for the elements of a vector memory access whose per-element offsets follow bit-reversed order. That is the permutation that radix-2 FFT and DCT butterfly passes need. A start pulse captures a base address, a flag that forces the base term to zero, a signed displacement, an element size, a span shift and a vector length. The block then issues one address per cycle on a valid/ready output. Each address comes with its element index, and the final element carries a last flag.

Elements always go out in ascending index order. Only the offset is permuted: the index is reversed over log2(VL) bits, scaled by the sign-extended displacement and the element size, and then shifted left by the span amount. Later butterfly passes use the span amount to step through memory in radix-2 strides.

Top module: `bitrev_agen`

## Requirements
- R1: The address of element i is B + (((sext(disp) << size_log2) * rev(i)) << span_shift), computed modulo 2^ADDR_W. B is the captured base term. size_log2 codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 byte elements.
- R2: When base_zero is 1 at start, B is zero no matter what base_addr holds. Otherwise B is base_addr.
- R3: rev(i) reverses the low L bits of i, where L = vl_log2 and VL = 2^L. For VL=4 the order is 0,2,1,3. For VL=8 it is 0,4,2,6,1,5,3,7. A vl_log2 above MAX_LOG is treated as MAX_LOG.
- R4: span_shift 0 gives plain bit-reversed offsets. Each further unit of span_shift doubles every offset. With VL=4, base 0x10 and an 8-byte step, the addresses are 0x10, 0x20, 0x18, 0x28.
- R5: After a start is accepted while idle, out_valid rises on the next cycle with out_idx 0. out_idx then advances by one on every accepted transfer, up to VL-1.
- R6: out_last is 1 only on element VL-1. After that element is accepted, out_valid is 0 on the following cycle.
- R7: With VL=1 exactly one transfer occurs. Its address equals B and it has out_last set.
- R8: While out_valid is 1 and out_ready is 0, out_addr, out_idx and out_last hold their values.
- R9: A start pulse that arrives while a sequence is active is ignored. The running sequence continues unchanged.
- R10: A synchronous reset, taken at any time, returns the block to idle with out_valid 0 on the next cycle.
- R11: The configuration inputs are captured at start. Changes to them during a sequence do not affect the addresses being issued.
- R12: disp is a 16-bit two's complement value, sign-extended before scaling. A negative offset wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sequence (taken only when idle) |
| base_addr | input | ADDR_W | Base address |
| base_zero | input | 1 | Force the base term to zero |
| disp | input | DISP_W | Signed displacement |
| size_log2 | input | 2 | log2 of the element size in bytes |
| span_shift | input | SPAN_W | Radix-2 span shift amount |
| vl_log2 | input | LG_W | log2 of the vector length |
| out_valid | output | 1 | Address valid |
| out_ready | input | 1 | Consumer accepts the address |
| out_addr | output | ADDR_W | Effective address |
| out_idx | output | MAX_LOG | Element index (issue order) |
| out_last | output | 1 | Final element of the sequence |

## Verification
The bench builds two instances with the default widths: a 64-bit address, a 16-bit displacement, MAX_LOG of 6 (vectors up to 64 elements) and a 6-bit span field. One instance uses the shift-based reverser and the other the per-length candidate reverser, and their outputs are compared every cycle. These widths put the full 64-element permutation, spans large enough to push offsets past bit 63, and negative displacements that wrap the 64-bit sum all within reach. A vl_log2 of 7 also reaches the clamp.

// File: rtl/bitrev_agen_pkg.sv
package bitrev_agen_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // width of a shift count able to hold size + span
   function automatic int shift_width(input int span_w);
      return ((span_w > 2) ? span_w : 2) + 1;
   endfunction

   // bits needed to hold the value n
   function automatic int bits_for(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/bitrev_agen_rev.sv
module bitrev_agen_rev #(
   parameter int MAX_LOG   = 6,
   parameter int REV_STYLE = 0,
   parameter int LG_W      = bitrev_agen_pkg::bits_for(MAX_LOG)
) (
   input  logic [MAX_LOG-1:0] idx,
   input  logic [LG_W-1:0]    lg,
   output logic [MAX_LOG-1:0] rev
);

   generate
      if (REV_STYLE == 0) begin : g_shift
         // reverse across the full width, then move down to length lg
         logic [MAX_LOG-1:0] full;
         logic [LG_W-1:0]    drop;
         for (genvar b = 0; b < MAX_LOG; b++) begin : g_bit
            assign full[b] = idx[MAX_LOG-1-b];
         end
         assign drop = LG_W'(MAX_LOG) - lg;
         assign rev  = full >> drop;
      end else begin : g_cand
         // one candidate per length, selected by lg
         logic [MAX_LOG-1:0] cand [MAX_LOG+1];
         for (genvar l = 0; l <= MAX_LOG; l++) begin : g_len
            for (genvar b = 0; b < MAX_LOG; b++) begin : g_bit
               if (b < l) begin : g_on
                  assign cand[l][b] = idx[l-1-b];
               end else begin : g_off
                  assign cand[l][b] = 1'b0;
               end
            end
         end
         always_comb begin
            rev = '0;
            for (int l = 0; l <= MAX_LOG; l++) begin
               if (lg == LG_W'(l)) rev = cand[l];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bitrev_agen_scale.sv
module bitrev_agen_scale #(
   parameter int ADDR_W  = 64,
   parameter int DISP_W  = 16,
   parameter int MAX_LOG = 6,
   parameter int SPAN_W  = 6
) (
   input  logic [DISP_W-1:0]  disp,
   input  logic [MAX_LOG-1:0] rev,
   input  logic [1:0]         size_log2,
   input  logic [SPAN_W-1:0]  span_shift,
   output logic [ADDR_W-1:0]  offset
);

   localparam int SH_W = bitrev_agen_pkg::shift_width(SPAN_W);

   logic [ADDR_W-1:0] sdisp;
   logic [ADDR_W-1:0] pp [MAX_LOG];
   logic [ADDR_W-1:0] prod;
   logic [SH_W-1:0]   tot_sh;

   assign sdisp = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};

   // shift-add product of displacement and reversed index
   generate
      for (genvar b = 0; b < MAX_LOG; b++) begin : g_pp
         assign pp[b] = rev[b] ? (sdisp << b) : '0;
      end
   endgenerate

   always_comb begin
      prod = '0;
      for (int b = 0; b < MAX_LOG; b++) prod = prod + pp[b];
   end

   // element size and span fold into one barrel shift
   assign tot_sh = SH_W'(span_shift) + SH_W'(size_log2);
   assign offset = prod << tot_sh;

endmodule

// File: rtl/bitrev_agen_seq.sv
module bitrev_agen_seq
   import bitrev_agen_pkg::*;
#(
   parameter int MAX_LOG = 6,
   parameter int LG_W    = bits_for(MAX_LOG)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [LG_W-1:0]    vl_lg_in,
   input  logic               ready,
   output logic               active,
   output logic               load,
   output logic [MAX_LOG-1:0] idx,
   output logic [LG_W-1:0]    lg,
   output logic               last
);

   seq_state_e         state_q;
   logic [LG_W-1:0]    lg_clamp;
   logic [MAX_LOG-1:0] end_idx;

   assign lg_clamp = (vl_lg_in > LG_W'(MAX_LOG)) ? LG_W'(MAX_LOG) : vl_lg_in;
   assign active   = (state_q == SEQ_RUN);
   assign load     = !active && start;
   assign end_idx  = MAX_LOG'((1 << lg) - 1);
   assign last     = active && (idx == end_idx);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         idx     <= '0;
         lg      <= '0;
      end else if (load) begin
         state_q <= SEQ_RUN;
         idx     <= '0;
         lg      <= lg_clamp;
      end else if (active && ready) begin
         if (last) state_q <= SEQ_IDLE;
         else      idx     <= idx + 1'b1;
      end
   end

endmodule

// File: rtl/bitrev_agen.sv
module bitrev_agen #(
   parameter int ADDR_W    = 64,
   parameter int DISP_W    = 16,
   parameter int MAX_LOG   = 6,
   parameter int SPAN_W    = 6,
   parameter int REV_STYLE = 0,
   parameter int LG_W      = bitrev_agen_pkg::bits_for(MAX_LOG)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic               base_zero,
   input  logic [DISP_W-1:0]  disp,
   input  logic [1:0]         size_log2,
   input  logic [SPAN_W-1:0]  span_shift,
   input  logic [LG_W-1:0]    vl_log2,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [ADDR_W-1:0]  out_addr,
   output logic [MAX_LOG-1:0] out_idx,
   output logic               out_last
);

   generate
      if (MAX_LOG < 1 || MAX_LOG > 6) begin : g_bad_log
         $error("bitrev_agen: MAX_LOG must lie in 1..6");
      end
      if (DISP_W < 2 || DISP_W > ADDR_W) begin : g_bad_disp
         $error("bitrev_agen: DISP_W must lie in 2..ADDR_W");
      end
      if (SPAN_W < 1) begin : g_bad_span
         $error("bitrev_agen: SPAN_W must be at least 1");
      end
      if (REV_STYLE != 0 && REV_STYLE != 1) begin : g_bad_style
         $error("bitrev_agen: REV_STYLE must be 0 or 1");
      end
   endgenerate

   logic               active, load, last;
   logic [MAX_LOG-1:0] idx, rev;
   logic [LG_W-1:0]    lg;
   logic [ADDR_W-1:0]  base_q, offset;
   logic [DISP_W-1:0]  disp_q;
   logic [1:0]         size_q;
   logic [SPAN_W-1:0]  span_q;

   bitrev_agen_seq #(.MAX_LOG(MAX_LOG), .LG_W(LG_W)) seq_i (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .vl_lg_in(vl_log2),
      .ready   (out_ready),
      .active  (active),
      .load    (load),
      .idx     (idx),
      .lg      (lg),
      .last    (last)
   );

   // configuration captured once per sequence
   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         disp_q <= '0;
         size_q <= '0;
         span_q <= '0;
      end else if (load) begin
         base_q <= base_zero ? '0 : base_addr;
         disp_q <= disp;
         size_q <= size_log2;
         span_q <= span_shift;
      end
   end

   bitrev_agen_rev #(.MAX_LOG(MAX_LOG), .REV_STYLE(REV_STYLE), .LG_W(LG_W)) rev_i (
      .idx(idx),
      .lg (lg),
      .rev(rev)
   );

   bitrev_agen_scale #(
      .ADDR_W(ADDR_W), .DISP_W(DISP_W), .MAX_LOG(MAX_LOG), .SPAN_W(SPAN_W)
   ) scale_i (
      .disp      (disp_q),
      .rev       (rev),
      .size_log2 (size_q),
      .span_shift(span_q),
      .offset    (offset)
   );

   assign out_valid = active;
   assign out_addr  = base_q + offset;
   assign out_idx   = idx;
   assign out_last  = last;

endmodule

// File: rtl/bitrev_agen_chk.sv
module bitrev_agen_chk #(
   parameter int ADDR_W  = 64,
   parameter int MAX_LOG = 6
) (
   input logic               clk,
   input logic               rst,
   input logic               start,
   input logic               out_valid,
   input logic               out_ready,
   input logic [ADDR_W-1:0]  out_addr,
   input logic [MAX_LOG-1:0] out_idx,
   input logic               out_last
);

   // R10
   reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);

   // R5
   start_first_chk: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && start) |=> (out_valid && out_idx == '0));

   // R5
   idx_step_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && !out_last) |=>
      (out_valid && out_idx == MAX_LOG'($past(out_idx) + 1'b1)));

   // R6
   last_end_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && out_last) |=> !out_valid);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_idx) && $stable(out_last)));

   // R6
   last_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_idx == '0 && !out_last) |=> !(out_valid && out_ready && out_idx == '0 && out_last));

endmodule

bind bitrev_agen bitrev_agen_chk #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_addr (out_addr),
   .out_idx  (out_idx),
   .out_last (out_last)
);

// File: tb/bitrev_agen_tb_top.sv
`timescale 1ns/1ps
module bitrev_agen_tb_top;

   typedef struct {
      logic [63:0] addr;
      logic [5:0]  idx;
      logic        last;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [63:0] base_addr = '0;
   logic        base_zero = 1'b0;
   logic [15:0] disp = '0;
   logic [1:0]  size_log2 = '0;
   logic [5:0]  span_shift = '0;
   logic [2:0]  vl_log2 = '0;
   logic        out_ready = 1'b1;
   logic        out_valid, out_last, b_valid, b_last;
   logic [63:0] out_addr, b_addr;
   logic [5:0]  out_idx, b_idx;

   int    checks = 0;
   int    failures = 0;
   item_t expq[$];
   string tag = "R1";
   bit    ready_rand = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   bit    mon_on = 1'b0;
   bit    expect_idle = 1'b0;
   bit    prev_stall = 1'b0;
   logic [63:0] prev_addr = '0;
   logic [5:0]  prev_idx = '0;

   always #2.5 clk = ~clk;

   bitrev_agen dut_i (
      .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
      .base_zero(base_zero), .disp(disp), .size_log2(size_log2),
      .span_shift(span_shift), .vl_log2(vl_log2), .out_valid(out_valid),
      .out_ready(out_ready), .out_addr(out_addr), .out_idx(out_idx),
      .out_last(out_last)
   );

   bitrev_agen #(.REV_STYLE(1)) alt_i (
      .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
      .base_zero(base_zero), .disp(disp), .size_log2(size_log2),
      .span_shift(span_shift), .vl_log2(vl_log2), .out_valid(b_valid),
      .out_ready(out_ready), .out_addr(b_addr), .out_idx(b_idx),
      .out_last(b_last)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [63:0] b, input bit bz,
      input logic [15:0] d, input logic [1:0] sz, input logic [5:0] sp,
      input int lg, input int i);
      logic [63:0] off;
      logic [63:0] r;
      r = '0;
      for (int k = 0; k < lg; k++) r[lg-1-k] = i[k];
      off = {{48{d[15]}}, d} << sz;
      off = off * r;
      off = off << sp;
      return (bz ? 64'd0 : b) + off;
   endfunction

   // ready pattern, changed just after each rising edge
   always @(posedge clk) begin
      #1;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= ready_rand ? lfsr[0] : 1'b1;
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (mon_on && !rst) begin
         check(b_valid == out_valid && (!out_valid ||
               (b_addr == out_addr && b_idx == out_idx && b_last == out_last)),
               "R3 reverser variants agree", b_addr, out_addr);
         if (prev_stall) begin
            check(out_valid && out_addr == prev_addr && out_idx == prev_idx,
                  "R8 stall hold", out_addr, prev_addr);
         end
         if (expect_idle) begin
            check(!out_valid, "R6 idle after last", 64'(out_valid), 64'd0);
            expect_idle = 1'b0;
         end
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               check(1'b0, "R9 unexpected transfer", out_addr, 64'd0);
            end else begin
               item_t e;
               e = expq.pop_front();
               check(out_addr == e.addr, tag, out_addr, e.addr);
               check(out_idx == e.idx, "R5 index order", 64'(out_idx), 64'(e.idx));
               check(out_last == e.last, "R6 last flag", 64'(out_last), 64'(e.last));
               if (out_last) expect_idle = 1'b1;
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_addr  = out_addr;
         prev_idx   = out_idx;
      end
   end

   task automatic run_seq(input string t, input logic [63:0] b, input bit bz,
      input logic [15:0] d, input logic [1:0] sz, input logic [5:0] sp,
      input logic [2:0] vlg, input bit rnd, input bit disturb);
      int lg;
      lg = (vlg > 3'd6) ? 6 : int'(vlg);
      tag = t;
      for (int i = 0; i < (1 << lg); i++) begin
         item_t e;
         e.addr = model(b, bz, d, sz, sp, lg, i);
         e.idx  = 6'(i);
         e.last = (i == (1 << lg) - 1);
         expq.push_back(e);
      end
      @(posedge clk); #1;
      ready_rand = rnd;
      base_addr = b; base_zero = bz; disp = d; size_log2 = sz;
      span_shift = sp; vl_log2 = vlg; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      if (disturb) begin
         // R9 / R11: new start and changed inputs mid-sequence
         @(posedge clk); #1;
         base_addr = 64'hFFFF_0000_0000_0000; base_zero = ~bz; disp = ~d;
         size_log2 = ~sz; span_shift = sp + 6'd5; vl_log2 = 3'd1; start = 1'b1;
         @(posedge clk); #1;
         start = 1'b0;
      end
      wait (expq.size() == 0);
      @(posedge clk); #1;
      @(posedge clk); #1;
   endtask

   task automatic main_flow();
      repeat (3) @(posedge clk);
      #1; rst = 1'b0;
      @(negedge clk);
      // R10 reset state
      check(!out_valid, "R10 reset idle", 64'(out_valid), 64'd0);
      mon_on = 1'b1;
      run_seq("R4 spec example", 64'h10, 1'b0, 16'd8, 2'd0, 6'd0, 3'd2, 1'b0, 1'b0);
      run_seq("R3 VL8 order", 64'h1000, 1'b0, 16'd4, 2'd1, 6'd0, 3'd3, 1'b1, 1'b0);
      run_seq("R4 span shift", 64'h2000, 1'b0, 16'd1, 2'd3, 6'd3, 3'd4, 1'b1, 1'b0);
      run_seq("R2 base zero", 64'hDEAD_BEEF_0000_1234, 1'b1, 16'd16, 2'd2, 6'd1, 3'd3, 1'b0, 1'b0);
      run_seq("R12 negative wrap", 64'h8, 1'b0, 16'hFFFD, 2'd2, 6'd0, 3'd3, 1'b1, 1'b0);
      run_seq("R7 single element", 64'h4321, 1'b0, 16'd100, 2'd3, 6'd2, 3'd0, 1'b0, 1'b0);
      run_seq("R3 clamp VL64", 64'h1_0000, 1'b0, 16'd3, 2'd0, 6'd0, 3'd7, 1'b1, 1'b0);
      run_seq("R1 large span", 64'h40, 1'b0, 16'h7FFF, 2'd3, 6'd58, 3'd3, 1'b0, 1'b0);
      run_seq("R9 R11 ignored start", 64'h500, 1'b0, 16'd12, 2'd1, 6'd2, 3'd3, 1'b1, 1'b1);
      // R10 reset mid-sequence
      tag = "R10 before reset";
      @(posedge clk); #1;
      ready_rand = 1'b0; base_addr = 64'h900; base_zero = 1'b0; disp = 16'd8;
      size_log2 = 2'd0; span_shift = 6'd0; vl_log2 = 3'd4; start = 1'b1;
      for (int i = 0; i < 16; i++) begin
         item_t e;
         e.addr = model(64'h900, 1'b0, 16'd8, 2'd0, 6'd0, 4, i);
         e.idx = 6'(i); e.last = (i == 15);
         expq.push_back(e);
      end
      @(posedge clk); #1; start = 1'b0;
      repeat (3) @(posedge clk);
      #1; rst = 1'b1;
      @(posedge clk); #1; rst = 1'b0;
      expq.delete(); prev_stall = 1'b0; expect_idle = 1'b0;
      @(negedge clk);
      check(!out_valid, "R10 reset mid-sequence", 64'(out_valid), 64'd0);
      run_seq("R5 after reset", 64'h30, 1'b0, 16'd2, 2'd1, 6'd0, 3'd2, 1'b1, 1'b0);
   endtask

   initial begin
      fork
         main_flow();
         begin
            repeat (100000) @(posedge clk);
            check(1'b0, "watchdog", 64'd0, 64'd1);
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule